// File: doc/BRIEF.md
# Store Buffer with Load Forwarding for Total Store Order

This block sits between one processor core and a shared, single-ported memory. Stores from the core are written into a small circular queue and acknowledged at once, without waiting for the memory. The queued stores are later written to the shared memory strictly oldest first, one per cycle in which the memory arbiter grants the port. Every other agent therefore sees this core's stores in one fixed order.

Loads are not held behind the queue. A load whose address matches a queued store is answered from the queue with the data of the most recent such store, and the memory is not used. A load that matches nothing reads the shared memory ahead of any older queued stores. As a result a store followed by a load to a different address can appear reordered to other cores, which is the one relaxation total store order allows. A fence request holds off new core traffic until the queue is empty and then reports completion. This restores the ordering wherever software asks for it.

Top module: `tso_store_buffer`

## Requirements
- R1: While the queue holds fewer than DEPTH (default 8) stores and no fence is requested, `st_ready` is high, whatever the value of `mem_gnt`, and a store with `st_valid` high is taken on that clock edge.
- R2: Once DEPTH stores are queued and none has drained, `st_ready` is low and further stores are held off.
- R3: Queued stores are written to memory with `mem_req`=1 and `mem_we`=1 oldest first, in the order the core issued them, at most one per clock and only in a cycle with `mem_gnt` high. A queue of N stores with the grant held high is empty after N clocks.
- R4: A load that matches no queued store drives `mem_req`=1, `mem_we`=0 and `mem_addr`=`ld_addr`, taking the port ahead of any queued store. It is accepted (`ld_ready`=1) in a cycle with `mem_gnt` high, and its data is `mem_rdata` in the following cycle.
- R5: A load that matches one or more queued stores is accepted whatever the value of `mem_gnt` and issues no memory read. It returns the data of the youngest matching store.
- R6: Every load returns `ld_resp_valid`=1 with its data exactly one cycle after the cycle it is accepted, and `ld_resp_valid` is low in every other cycle.
- R7: A load that matches no queued store can complete while older stores are still queued and not yet written to memory.
- R8: While `fence_req` is high, `st_ready` and `ld_ready` are low. `fence_done` rises for one cycle, one cycle after a cycle in which `fence_req` is high and the queue is empty. It is never high while stores remain queued.
- R9: Asserting `rst_n` low discards all queued stores and clears `fence_done` and `ld_resp_valid`. A later load to a discarded address reads memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Core presents a store |
| st_ready | output | 1 | Store accepted on this edge |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core presents a load |
| ld_ready | output | 1 | Load accepted on this edge |
| ld_addr | input | AW | Load word address |
| ld_resp_valid | output | 1 | Load data valid |
| ld_resp_data | output | DW | Load data |
| fence_req | input | 1 | Core requests a full fence, held until done |
| fence_done | output | 1 | Fence complete, queue drained |
| mem_req | output | 1 | Memory port request |
| mem_we | output | 1 | 1 for a store drain, 0 for a load read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Arbiter grant for this cycle |
| mem_rdata | input | DW | Read data, valid the cycle after a granted read |

## Verification
The bound checker watches, on every cycle, the local rules: no store is accepted into a full queue, each granted drain removes exactly one entry, a matching load never starts a memory read, every accepted load answers one cycle later and never otherwise, and fence completion and fence stalls line up with an empty queue. The properties that concern data and order need the bench's scenarios. These are youngest-match selection among several stores to one address, the exact oldest-first sequence of writes at the memory, loads completing while older stores are still invisible in memory, and the discarding of queued stores by reset.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
  // Owner of the shared memory port in the current cycle.
  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_LOAD  = 2'd1,
    PORT_DRAIN = 2'd2
  } port_use_e;
endpackage

// File: rtl/sb_queue.sv
`timescale 1ns/1ps
module sb_queue #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_i,
  input  logic [AW-1:0]               push_addr_i,
  input  logic [DW-1:0]               push_data_i,
  input  logic                        pop_i,
  output logic [DEPTH-1:0][AW-1:0]    q_addr_o,
  output logic [DEPTH-1:0][DW-1:0]    q_data_o,
  output logic [PW-1:0]               head_o,
  output logic [CW-1:0]               count_o,
  output logic                        full_o,
  output logic                        empty_o
);

  logic [PW-1:0]            head_q, head_d, tail_q, tail_d;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic                     do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_comb begin
    head_d = do_pop  ? step(head_q) : head_q;
    tail_d = do_push ? step(tail_q) : tail_q;
    cnt_d  = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // Payload storage: no reset, written only under its enable.
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_push && (tail_q == PW'(i))) begin
        addr_q[i] <= push_addr_i;
        data_q[i] <= push_data_i;
      end
    end
  end

  assign q_addr_o = addr_q;
  assign q_data_o = data_q;
  assign head_o   = head_q;
  assign count_o  = cnt_q;

endmodule

// File: rtl/sb_fwd.sv
`timescale 1ns/1ps
module sb_fwd #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int XW   = (PW + 1 > CW) ? PW + 1 : CW
) (
  input  logic [AW-1:0]            ld_addr_i,
  input  logic [DEPTH-1:0][AW-1:0] q_addr_i,
  input  logic [DEPTH-1:0][DW-1:0] q_data_i,
  input  logic [PW-1:0]            head_i,
  input  logic [CW-1:0]            count_i,
  output logic                     hit_o,
  output logic [DW-1:0]            data_o
);

  logic [DEPTH-1:0] match;

  // Per slot: live if its age behind the head is below the fill count.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [XW-1:0] age;
    always_comb begin
      age = XW'(g) + XW'(DEPTH) - XW'(head_i);
      if (age >= XW'(DEPTH)) age = age - XW'(DEPTH);
    end
    assign match[g] = (age < XW'(count_i)) && (q_addr_i[g] == ld_addr_i);
  end

  // Walk from oldest to youngest; the last match found is the youngest.
  logic [XW-1:0] pos;
  logic [PW-1:0] idx;
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    pos    = '0;
    idx    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = XW'(head_i) + XW'(k);
      if (pos >= XW'(DEPTH)) pos = pos - XW'(DEPTH);
      idx = pos[PW-1:0];
      if (match[idx]) begin
        hit_o  = 1'b1;
        data_o = q_data_i[idx];
      end
    end
  end

endmodule

// File: rtl/tso_store_buffer.sv
`timescale 1ns/1ps
module tso_store_buffer #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_resp_valid,
  output logic [DW-1:0] ld_resp_data,
  input  logic          fence_req,
  output logic          fence_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata
);
  import sb_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][AW-1:0] q_addr;
  logic [DEPTH-1:0][DW-1:0] q_data;
  logic [PW-1:0]            q_head;
  logic [CW-1:0]            q_count;
  logic                     q_full, q_empty;
  logic                     fwd_hit;
  logic [DW-1:0]            fwd_data;
  logic                     push, pop, ld_take, ld_miss_want;
  port_use_e                port_use;

  logic          resp_v_q, resp_v_d;
  logic          resp_fwd_q, resp_fwd_d;
  logic [DW-1:0] fwd_data_q;
  logic          fwd_data_en;
  logic          fence_done_q, fence_done_d;

  sb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .push_addr_i (st_addr),
    .push_data_i (st_data),
    .pop_i       (pop),
    .q_addr_o    (q_addr),
    .q_data_o    (q_data),
    .head_o      (q_head),
    .count_o     (q_count),
    .full_o      (q_full),
    .empty_o     (q_empty)
  );

  sb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
    .ld_addr_i (ld_addr),
    .q_addr_i  (q_addr),
    .q_data_i  (q_data),
    .head_i    (q_head),
    .count_i   (q_count),
    .hit_o     (fwd_hit),
    .data_o    (fwd_data)
  );

  // Port ownership: a missing load goes first, otherwise the head drains.
  always_comb begin
    ld_miss_want = ld_valid && !fence_req && !fwd_hit;
    if (ld_miss_want)  port_use = PORT_LOAD;
    else if (!q_empty) port_use = PORT_DRAIN;
    else               port_use = PORT_IDLE;
  end

  assign mem_req   = (port_use != PORT_IDLE);
  assign mem_we    = (port_use == PORT_DRAIN);
  assign mem_addr  = (port_use == PORT_LOAD) ? ld_addr : q_addr[q_head];
  assign mem_wdata = q_data[q_head];
  assign pop       = (port_use == PORT_DRAIN) && mem_gnt;

  assign st_ready  = !q_full && !fence_req;
  assign push      = st_valid && st_ready;
  assign ld_ready  = !fence_req && (fwd_hit || mem_gnt);
  assign ld_take   = ld_valid && ld_ready;

  always_comb begin
    resp_v_d     = ld_take;
    resp_fwd_d   = ld_take && fwd_hit;
    fwd_data_en  = ld_take && fwd_hit;
    fence_done_d = fence_req && q_empty && !fence_done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_v_q     <= 1'b0;
      resp_fwd_q   <= 1'b0;
      fence_done_q <= 1'b0;
    end else begin
      resp_v_q     <= resp_v_d;
      resp_fwd_q   <= resp_fwd_d;
      fence_done_q <= fence_done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fwd_data_en) fwd_data_q <= fwd_data;
  end

  assign ld_resp_valid = resp_v_q;
  assign ld_resp_data  = resp_fwd_q ? fwd_data_q : mem_rdata;
  assign fence_done    = fence_done_q;

endmodule

// File: rtl/sb_chk.sv
`timescale 1ns/1ps
module sb_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic          ld_valid,
  input logic          ld_ready,
  input logic          ld_resp_valid,
  input logic          fence_req,
  input logic          fence_done,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [CW-1:0] count,
  input logic          fwd_hit
);

  // R2
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |-> (count < CW'(DEPTH)));

  // R3
  drain_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (count != '0));

  // R3
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_gnt && !(st_valid && st_ready))
      |=> (count == $past(count) - 1'b1));

  // R5
  hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && fwd_hit) |-> !(mem_req && !mem_we));

  // R6
  resp_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> ld_resp_valid);

  // R6
  resp_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_valid && ld_ready) |=> !ld_resp_valid);

  // R8
  fence_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_done |-> (count == '0));

  // R8
  fence_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fence_req |-> (!st_ready && !ld_ready));

endmodule

bind tso_store_buffer sb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st_valid      (st_valid),
  .st_ready      (st_ready),
  .ld_valid      (ld_valid),
  .ld_ready      (ld_ready),
  .ld_resp_valid (ld_resp_valid),
  .fence_req     (fence_req),
  .fence_done    (fence_done),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_gnt       (mem_gnt),
  .count         (q_count),
  .fwd_hit       (fwd_hit)
);

// File: tb/sim_tso_store_buffer.sv
`timescale 1ns/1ps
module sim_tso_store_buffer;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 8;
  localparam int NV = 8;
  // Vector table: op 0 = store, 1 = load; for loads DAT is the expected data.
  localparam int          OP  [NV] = '{0, 0, 1, 1, 0, 1, 1, 1};
  localparam logic [31:0] ADR [NV] = '{1, 2, 1, 3, 1, 1, 2, 5};
  localparam logic [31:0] DAT [NV] = '{11, 22, 11, 103, 33, 33, 22, 105};
  localparam bit          MISS[NV] = '{0, 0, 0, 1, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_n;
  logic st_valid, st_ready, ld_valid, ld_ready, ld_resp_valid;
  logic fence_req, fence_done, mem_req, mem_we, mem_gnt;
  logic [AW-1:0] st_addr, ld_addr, mem_addr;
  logic [DW-1:0] st_data, ld_resp_data, mem_wdata, mem_rdata;

  int tests = 0;
  int fails = 0;

  logic [31:0] mem [16];
  logic [31:0] wlog_a [32];
  logic [31:0] wlog_d [32];
  int wn = 0;

  always #10 clk = ~clk;

  tso_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .ld_resp_valid(ld_resp_valid), .ld_resp_data(ld_resp_data),
    .fence_req(fence_req), .fence_done(fence_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  // Shared memory model: write on a granted drain, registered read data.
  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[3:0]] <= mem_wdata;
        wlog_a[wn] <= mem_addr;
        wlog_d[wn] <= mem_wdata;
        wn <= wn + 1;
      end else begin
        mem_rdata <= mem[mem_addr[3:0]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [31:0] exp,
                         input string tag, input bit miss);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; mem_gnt = miss;
    #1;
    if (miss) begin
      chk({tag, " read ahead of drain"}, {30'd0, mem_req, mem_we}, 32'd2);
      chk({tag, " read address"}, mem_addr, a);
    end else begin
      chk({tag, " hit accepted without grant"}, {31'd0, ld_ready}, 32'd1);
      chk({tag, " hit issues no read"}, {31'd0, mem_req && !mem_we}, 32'd0);
    end
    while (!ld_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ld_valid = 1'b0; mem_gnt = 1'b0;
    @(negedge clk);
    chk("R6 response valid", {31'd0, ld_resp_valid}, 32'd1);
    chk({tag, " load data"}, ld_resp_data, exp);
  endtask

  task automatic do_fence(input int exp_cyc);
    int cyc;
    @(negedge clk);
    fence_req = 1'b1; mem_gnt = 1'b1;
    #1;
    chk("R8 stall during fence", {30'd0, st_ready, ld_ready}, 32'd0);
    cyc = 0;
    while (!fence_done && cyc < 50) begin @(negedge clk); #1; cyc++; end
    chk("R8 fence done", {31'd0, fence_done}, 32'd1);
    chk("R3 drain one per clock", cyc, exp_cyc);
    fence_req = 1'b0; mem_gnt = 1'b0;
    @(negedge clk);
    chk("R8 fence done one cycle", {31'd0, fence_done}, 32'd0);
  endtask

  initial begin
    #4_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'(100 + i);
    mem_rdata = '0;
    rst_n = 1'b0; st_valid = 0; ld_valid = 0; fence_req = 0; mem_gnt = 0;
    st_addr = '0; st_data = '0; ld_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset st_ready", {31'd0, st_ready}, 32'd1);
    chk("R9 reset queue empty", {31'd0, mem_req}, 32'd0);
    chk("R9 reset no response", {31'd0, ld_resp_valid}, 32'd0);
    chk("R9 reset fence_done", {31'd0, fence_done}, 32'd0);

    // Vector table: grant only for missing loads, so stores stay queued.
    for (int i = 0; i < NV; i++) begin
      if (OP[i] == 0) do_store(ADR[i], DAT[i]);
      else do_load(ADR[i], DAT[i], MISS[i] ? "R4" : "R5", MISS[i]);
    end
    // R7: loads completed while older stores are still invisible in memory
    chk("R7 store 1 not yet in memory", mem[1], 32'd101);
    chk("R7 store 2 not yet in memory", mem[2], 32'd102);
    chk("R7 no writes yet", wn, 32'd0);

    // R3 / R8: fence drains three stores in three clocks, done the next
    do_fence(4);
    chk("R3 write count", wn, 32'd3);
    chk("R3 order addr 0", wlog_a[0], 32'd1);
    chk("R3 order data 0", wlog_d[0], 32'd11);
    chk("R3 order addr 1", wlog_a[1], 32'd2);
    chk("R3 order data 1", wlog_d[1], 32'd22);
    chk("R3 order addr 2", wlog_a[2], 32'd1);
    chk("R3 order data 2", wlog_d[2], 32'd33);
    chk("R3 final memory", mem[1], 32'd33);
    // R8: fence on an empty queue completes one cycle later
    do_fence(1);

    // R1 / R2: fill the queue with no grant
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); #1;
      chk("R1 ready with grant low", {31'd0, st_ready}, 32'd1);
      do_store(32'(8 + i), 32'(200 + i));
    end
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'd15; st_data = 32'd999;
    repeat (3) begin
      #1; chk("R2 full back-pressure", {31'd0, st_ready}, 32'd0);
      @(negedge clk);
    end
    st_valid = 1'b0;
    do_load(32'd9, 32'd201, "R5", 1'b0);

    // R9: reset mid-operation discards the queued stores
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9 queue emptied", {31'd0, mem_req}, 32'd0);
    chk("R9 ready after reset", {31'd0, st_ready}, 32'd1);
    chk("R9 fence_done cleared", {31'd0, fence_done}, 32'd0);
    do_load(32'd9, 32'd109, "R9", 1'b1);
    chk("R9 discarded stores never written", wn, 32'd3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule